// File: doc/BRIEF.md
# No-Operation Instruction Length Decoder

This block sits beside the fetch stage and looks at a window of instruction bytes that begins exactly at an instruction boundary. It answers one question: do these bytes form a no-operation instruction, and if so how many bytes long is it? With that answer the fetch stage can move the instruction pointer forward and never dispatch any register or memory work. The block covers the single-byte form (0x90), the two-byte-opcode form (0x0F 0x1F plus an addressing byte), and either one preceded by operand-size (0x66) and lock (0xF0) prefix bytes.

For the two-byte-opcode form the addressing byte, the optional index byte and the displacement are decoded only to find the length. They are never turned into an address. A lock prefix raises an invalid-opcode indication, and so does the two-byte-opcode form while the wide-NOP enable input is low. Any byte pattern that is not a no-operation instruction is reported with every flag low, so that a general decoder can take over. A byte-count input states how many window bytes are valid. When too few bytes are present to reach a verdict, the block asks for more bytes instead of giving a result. The block behaves the same in every processor mode.

Top module: `nop_len_decoder`

## Requirements
- R1: Window byte 0 is `win_bytes[7:0]` and byte k is `win_bytes[8k+7:8k]`. When no prefix is present, a first byte of 0x90 gives `is_nop`=1 and `nop_len`=1.
- R2: The bytes 0x0F 0x1F followed by an addressing byte whose bits [5:3] are 0 form a no-operation instruction. If bits [7:6] of that byte equal 3, the length is 3.
- R3: The length of the two-byte-opcode form is 3 plus extra bytes, found from addressing-byte fields mod=[7:6] and rm=[2:0]. mod=1 adds 1 and mod=2 adds 4. mod=0 with rm=5 adds 4. If rm=4 and mod is not 3, an index byte adds 1, and that byte's bits [2:0]=5 together with mod=0 add 4 more.
- R4: The padding sequences 66 90 / 0F 1F 00 / 0F 1F 40 00 / 0F 1F 44 00 00 / 66 0F 1F 44 00 00 / 0F 1F 80 00 00 00 00 / 0F 1F 84 00 00 00 00 00 / 66 0F 1F 84 00 00 00 00 00 decode to the lengths 2 through 9.
- R5: A lock prefix byte (0xF0) in front of 0x90, or in front of the two-byte-opcode form whose reg field is 0, gives `inval_op`=1 and `is_nop`=0.
- R6: While `wide_nop_en`=0, the bytes 0x0F 0x1F give `inval_op`=1 whatever follows, and only those two opcode bytes need to be present.
- R7: Up to MAX_PFX (2) leading bytes that are 0x66 or 0xF0 are treated as prefixes and count toward `nop_len`. A further 0x66 is taken as the opcode byte, so the instruction is not a no-operation instruction.
- R8: An addressing byte with a nonzero reg field, or any other opcode, gives `is_nop`=0, `inval_op`=0 and `need_more`=0. This includes a locked two-byte-opcode form whose reg field is nonzero.
- R9: When `byte_count` is below the number of bytes needed to reach the verdict, `need_more`=1 and no other flag is set. A count equal to that number is enough.
- R10: `out_valid` is high in the cycle after each cycle with `in_valid`=1 and low otherwise. The result outputs change only on a strobe and hold their values between strobes.
- R11: At most one of `is_nop`, `inval_op` and `need_more` is high, and `nop_len` is 0 unless `is_nop` is high.
- R12: While `rst` is high, all outputs go to 0 at the clock edge (synchronous, active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window strobe |
| win_bytes | input | 128 | Instruction bytes, byte 0 in the low bits |
| byte_count | input | 5 | Number of valid window bytes (0 to 16) |
| wide_nop_en | input | 1 | Enables the two-byte-opcode form |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| is_nop | output | 1 | Window starts with a no-operation instruction |
| inval_op | output | 1 | Invalid-opcode indication |
| need_more | output | 1 | Window too short for a verdict |
| nop_len | output | 4 | Instruction length in bytes when `is_nop` |

## Verification
The bench builds the block with its defaults: a 16-byte window, a 5-bit count and MAX_PFX=2. The two-prefix limit makes both sides of the prefix boundary reachable. 66 66 90 still decodes, and a third 0x66 ends the prefix run. With these values the longest case is also reachable: prefixed, index byte and 32-bit displacement together. Byte counts of zero, one short of the length and exactly the length cover both sides of the short-window decision.

// File: rtl/nopdec_pkg.sv
package nopdec_pkg;

    localparam logic [7:0] OPC_NOP1  = 8'h90;
    localparam logic [7:0] OPC_ESC   = 8'h0F;
    localparam logic [7:0] OPC_NOPW  = 8'h1F;
    localparam logic [7:0] PFX_OSIZE = 8'h66;
    localparam logic [7:0] PFX_LOCK  = 8'hF0;

    typedef enum logic [1:0] {
        V_OTHER = 2'd0,
        V_NOP   = 2'd1,
        V_FAULT = 2'd2
    } verdict_t;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } addr_byte_t;

    // Bytes that follow the addressing byte: index byte plus displacement.
    function automatic logic [2:0] addr_extra(input logic [7:0] ab, input logic [7:0] ib);
        addr_byte_t a;
        logic [2:0] n;
        a = addr_byte_t'(ab);
        n = 3'd0;
        if (a.mode != 2'd3) begin
            if (a.rm == 3'd4) begin
                n = 3'd1;
                if (a.mode == 2'd0 && ib[2:0] == 3'd5) n = n + 3'd4;
            end
            if (a.mode == 2'd1)                     n = n + 3'd1;
            else if (a.mode == 2'd2)                n = n + 3'd4;
            else if (a.mode == 2'd0 && a.rm == 3'd5) n = n + 3'd4;
        end
        return n;
    endfunction

endpackage

// File: rtl/nopdec_prefix_scan.sv
module nopdec_prefix_scan
    import nopdec_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int MAX_PFX   = 2,
    parameter int PC_W      = $clog2(MAX_PFX + 1)
) (
    input  logic [WIN_BYTES*8-1:0] win,
    output logic [PC_W-1:0]        pfx_cnt,
    output logic                   lock_seen
);

    logic [MAX_PFX-1:0] is_pfx;
    logic [MAX_PFX-1:0] is_lock;
    logic [MAX_PFX-1:0] run;

    for (genvar i = 0; i < MAX_PFX; i++) begin : g_pfx
        assign is_lock[i] = (win[8*i +: 8] == PFX_LOCK);
        assign is_pfx[i]  = (win[8*i +: 8] == PFX_OSIZE) || is_lock[i];
        if (i == 0) begin : g_first
            assign run[i] = is_pfx[i];
        end else begin : g_next
            assign run[i] = run[i-1] & is_pfx[i];
        end
    end

    assign pfx_cnt   = PC_W'($countones(run));
    assign lock_seen = |(run & is_lock);

endmodule

// File: rtl/nopdec_classify.sv
module nopdec_classify
    import nopdec_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int PC_W      = 2,
    parameter int NB_W      = 6
) (
    input  logic [WIN_BYTES*8-1:0] win,
    input  logic [PC_W-1:0]        pfx_cnt,
    input  logic                   lock_seen,
    input  logic                   wide_en,
    output verdict_t               verdict,
    output logic [NB_W-1:0]        needed,
    output logic [NB_W-1:0]        length
);

    function automatic logic [7:0] pick(input logic [WIN_BYTES*8-1:0] w, input logic [NB_W-1:0] k);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (k == NB_W'(i)) r = w[8*i +: 8];
        end
        return r;
    endfunction

    logic [NB_W-1:0] p;
    logic [7:0]      op0, op1, ab, ib;

    assign p   = NB_W'(pfx_cnt);
    assign op0 = pick(win, p);
    assign op1 = pick(win, p + NB_W'(1));
    assign ab  = pick(win, p + NB_W'(2));
    assign ib  = pick(win, p + NB_W'(3));

    always_comb begin
        verdict = V_OTHER;
        needed  = p + NB_W'(1);
        length  = '0;
        if (op0 == OPC_NOP1) begin
            verdict = lock_seen ? V_FAULT : V_NOP;
            length  = p + NB_W'(1);
        end else if (op0 == OPC_ESC) begin
            needed = p + NB_W'(2);
            if (op1 == OPC_NOPW) begin
                if (!wide_en) begin
                    verdict = V_FAULT;
                end else begin
                    needed = p + NB_W'(3);
                    if (ab[5:3] == 3'd0) begin
                        if (lock_seen) begin
                            verdict = V_FAULT;
                        end else begin
                            verdict = V_NOP;
                            needed  = p + NB_W'(3) + NB_W'(addr_extra(ab, ib));
                            length  = needed;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/nop_len_decoder.sv
module nop_len_decoder
    import nopdec_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int MAX_PFX   = 2,
    parameter int CNT_W     = $clog2(WIN_BYTES + 1),
    parameter int LEN_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [WIN_BYTES*8-1:0] win_bytes,
    input  logic [CNT_W-1:0]       byte_count,
    input  logic                   wide_nop_en,
    output logic                   out_valid,
    output logic                   is_nop,
    output logic                   inval_op,
    output logic                   need_more,
    output logic [LEN_W-1:0]       nop_len
);

    localparam int PC_W = $clog2(MAX_PFX + 1);
    localparam int NB_W = CNT_W + 1;

    logic [PC_W-1:0] pfx_cnt;
    logic            lock_seen;
    verdict_t        verdict;
    logic [NB_W-1:0] needed;
    logic [NB_W-1:0] length;
    logic            short_win;

    nopdec_prefix_scan #(
        .WIN_BYTES(WIN_BYTES), .MAX_PFX(MAX_PFX), .PC_W(PC_W)
    ) u_scan (
        .win(win_bytes), .pfx_cnt(pfx_cnt), .lock_seen(lock_seen)
    );

    nopdec_classify #(
        .WIN_BYTES(WIN_BYTES), .PC_W(PC_W), .NB_W(NB_W)
    ) u_cls (
        .win(win_bytes), .pfx_cnt(pfx_cnt), .lock_seen(lock_seen),
        .wide_en(wide_nop_en), .verdict(verdict), .needed(needed), .length(length)
    );

    assign short_win = needed > NB_W'(byte_count);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            is_nop    <= 1'b0;
            inval_op  <= 1'b0;
            need_more <= 1'b0;
            nop_len   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                need_more <= short_win;
                is_nop    <= !short_win && verdict == V_NOP;
                inval_op  <= !short_win && verdict == V_FAULT;
                nop_len   <= (!short_win && verdict == V_NOP) ? LEN_W'(length) : '0;
            end
        end
    end

    assert_one_flag_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({is_nop, inval_op, need_more}) <= 1);

    assert_len_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> nop_len == '0);

    assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(is_nop) && $stable(nop_len) && $stable(inval_op));

    assert_len_fits_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !is_nop || (CNT_W'(nop_len) <= $past(byte_count) && nop_len != '0));

endmodule

// File: tb/nop_len_decoder_bench.sv
module nop_len_decoder_bench;

    localparam int WB = 16;

    typedef struct packed {
        logic [71:0] seq;   // instruction order, first byte in the top 8 bits
        logic [4:0]  cnt;
        logic        en;
        logic [1:0]  kind;  // 0 other, 1 nop, 2 invalid, 3 need more
        logic [3:0]  len;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{72'h90_00_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd1, 4'd1},  // R1
        '{72'h66_90_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd2, 4'd4},  // R4
        '{72'h0F_1F_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd3, 4'd4},
        '{72'h0F_1F_40_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd4, 4'd4},
        '{72'h0F_1F_44_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd5, 4'd4},
        '{72'h66_0F_1F_44_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd6, 4'd4},
        '{72'h0F_1F_80_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd7, 4'd4},
        '{72'h0F_1F_84_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd8, 4'd4},
        '{72'h66_0F_1F_84_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd9, 4'd4},
        '{72'h0F_1F_C0_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd3, 4'd2},  // R2
        '{72'h0F_1F_05_11_22_33_44_00_00, 5'd16, 1'b1, 2'd1, 4'd7, 4'd3},  // R3 rm5 disp
        '{72'h0F_1F_04_05_11_22_33_44_00, 5'd16, 1'b1, 2'd1, 4'd8, 4'd3},  // R3 index base5
        '{72'h0F_1F_44_25_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd5, 4'd3},  // R3 base5 mod1
        '{72'hF0_90_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd2, 4'd0, 4'd5},  // R5
        '{72'hF0_0F_1F_00_00_00_00_00_00, 5'd16, 1'b1, 2'd2, 4'd0, 4'd5},
        '{72'h0F_1F_00_00_00_00_00_00_00, 5'd16, 1'b0, 2'd2, 4'd0, 4'd6},  // R6
        '{72'h0F_1F_00_00_00_00_00_00_00, 5'd2,  1'b0, 2'd2, 4'd0, 4'd6},
        '{72'h0F_1F_08_00_00_00_00_00_00, 5'd16, 1'b1, 2'd0, 4'd0, 4'd8},  // R8
        '{72'h0F_0B_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd0, 4'd0, 4'd8},
        '{72'h55_00_00_00_00_00_00_00_00, 5'd16, 1'b1, 2'd0, 4'd0, 4'd8},
        '{72'hF0_0F_1F_08_00_00_00_00_00, 5'd16, 1'b1, 2'd0, 4'd0, 4'd8},
        '{72'h0F_1F_80_00_00_00_00_00_00, 5'd6,  1'b1, 2'd3, 4'd0, 4'd9},  // R9
        '{72'h90_00_00_00_00_00_00_00_00, 5'd0,  1'b1, 2'd3, 4'd0, 4'd9},
        '{72'h0F_1F_84_00_00_00_00_00_00, 5'd8,  1'b1, 2'd1, 4'd8, 4'd9},
        '{72'h66_66_90_00_00_00_00_00_00, 5'd16, 1'b1, 2'd1, 4'd3, 4'd7},  // R7
        '{72'h66_66_66_90_00_00_00_00_00, 5'd16, 1'b1, 2'd0, 4'd0, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [WB*8-1:0] win_bytes = '0;
    logic [4:0]    byte_count = '0;
    logic          wide_nop_en = 1'b1;
    logic          out_valid, is_nop, inval_op, need_more;
    logic [3:0]    nop_len;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    nop_len_decoder u_nop_len_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .win_bytes(win_bytes),
        .byte_count(byte_count), .wide_nop_en(wide_nop_en), .out_valid(out_valid),
        .is_nop(is_nop), .inval_op(inval_op), .need_more(need_more), .nop_len(nop_len)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] pack_out();
        return {out_valid, is_nop, inval_op, need_more, nop_len};
    endfunction

    function automatic logic [7:0] expect_of(input logic [1:0] kind, input logic [3:0] len);
        return {1'b1, kind == 2'd1, kind == 2'd2, kind == 2'd3, len};
    endfunction

    task automatic apply(input logic [71:0] seq, input logic [4:0] cnt, input logic en);
        @(negedge clk);
        win_bytes = '0;
        for (int i = 0; i < 9; i++) win_bytes[8*i +: 8] = seq[71-8*i -: 8];
        byte_count  = cnt;
        wide_nop_en = en;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset outputs", pack_out(), 8'h00);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].seq, VECS[v].cnt, VECS[v].en);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), pack_out(),
                  expect_of(VECS[v].kind, VECS[v].len));
            // R11: at most one flag, covered by each expected value above
        end

        // R10: without a strobe the result holds and out_valid drops
        apply(72'h0F_1F_84_00_00_00_00_00_00, 5'd16, 1'b1);
        @(negedge clk);
        win_bytes = '0;
        win_bytes[7:0] = 8'h55;
        @(negedge clk);
        check("R10 hold without strobe", pack_out(), 8'h48);

        // R10: back-to-back strobes give back-to-back results
        @(negedge clk);
        win_bytes = '0; win_bytes[7:0] = 8'h90; byte_count = 5'd16; in_valid = 1'b1;
        @(negedge clk);
        check("R10 first of pair", pack_out(), 8'hC1);
        win_bytes[7:0] = 8'hF0; win_bytes[15:8] = 8'h90;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second of pair", pack_out(), 8'hA0);

        // R12: reset mid-run clears a held result
        apply(72'h0F_1F_00_00_00_00_00_00_00, 5'd16, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset after result", pack_out(), 8'h00);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule